// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from a set of sources that each have a fixed rank. Source 0 ranks highest. A rising edge on a request line is caught in a pending latch, so a device that pulses its line for a single cycle is still served. The controller drives one interrupt line to the processor. Beside that line it presents the binary index of the highest-ranked source that may interrupt now.

The controller also records which ranks are being serviced. While a service is open, requests at that rank and below are held back. A request of strictly higher rank interrupts again, so services nest. An acknowledge moves the reported source from pending to in-service and returns a one-hot grant to that device. An end-of-service pulse closes the highest-ranked open service.

A build parameter chooses how the winner is found. The first choice is a parallel priority encoder. The second is a ripple chain, in which the acknowledge token enters at position 0 and the first position with an eligible request keeps it rather than passing it on. Both choices give the same results at the ports.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous active-low reset, no source is pending or in service, `irq_out` is 0 and `grant` is all zeros.
- R2: A 0-to-1 transition on `irq_req[i]`, seen at a clock edge, sets the pending latch of source i. The latch stays set until that source is acknowledged, even if the request line falls. A request line that stays high does not set the latch again.
- R3: Among the eligible pending sources, the one with the lowest index is reported on `irq_code` as an unsigned binary number.
- R4: A pending source is eligible only if its index is strictly lower than every in-service index. `irq_out` is 1 exactly when at least one pending source is eligible.
- R5: When `irq_ack` is 1 and `irq_out` is 1, `grant` is one-hot at bit `irq_code` in that same cycle. At the next edge that source becomes in service and its pending latch clears.
- R6: When `irq_ack` is 1 and `irq_out` is 0, `grant` stays zero and no pending or in-service state changes.
- R7: `irq_eos` clears the in-service bit with the lowest index at the next edge. With nothing in service it has no effect. When an end-of-service and an acknowledge arrive in the same cycle, the end-of-service acts on the state before the acknowledge.
- R8: A higher-rank request that arrives during a service is reported and can be acknowledged, which nests the services. After its end-of-service, the lower-rank service masks again as before.
- R9: The ripple-chain selector and the parallel-encoder selector produce identical `irq_out`, `irq_code` and `grant` for any input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | NUM_SRC | Request lines from the sources; a rising edge is latched as pending |
| irq_ack | input | 1 | Acknowledge from the processor for the source reported now |
| irq_eos | input | 1 | End of service for the highest-ranked open service |
| irq_out | output | 1 | Interrupt line to the processor |
| irq_code | output | CODE_W | Binary index of the source that would be granted |
| grant | output | NUM_SRC | One-hot acknowledge returned to the granted source |

## Verification
The bench goes after several specific errors. A one-cycle request pulse must survive until it is acknowledged. A latch that followed the level would lose the pulse. An edge detector that was missing would re-raise the interrupt while the line stays high after service. Equal-rank requests must stay masked while that rank is in service. A mask that used "at or below" in place of "strictly below" would let a source nest on itself. An acknowledge with no interrupt showing must not produce a grant. End-of-service must close the highest open rank rather than the lowest, otherwise a nested service would unmask the wrong level. A long pseudo-random sweep over four sources compares every cycle with an arithmetic model, and it also compares the chain build with the encoder build.

// File: rtl/prio_intc_pkg.sv
// Shared types for the priority interrupt controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package prio_intc_pkg;
    // Winner-selection structure chosen at build time.
    typedef enum logic {
        SEL_ENCODER = 1'b0,
        SEL_CHAIN   = 1'b1
    } sel_kind_e;
endpackage

// File: rtl/intc_pending.sv
// Pending latches: catches the rising edge of each request line and holds it
// until the source is granted. Assumes irq_req is already synchronous to clk.
module intc_pending #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] rise;

    // Edge detect against the previous sample.
    assign rise = req & ~req_q;

    // Hold the previous request sample and the pending state; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~clr) | rise;
        end
    end

    assert_pulse_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));
    assert_clear_on_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~rise)) |=> ((pend & $past(clr & ~rise)) == '0));
endmodule

// File: rtl/intc_select.sv
// Finds the lowest-index set bit of a candidate vector and gives it as a binary
// code and as a one-hot vector. KIND picks a parallel encoder or a ripple chain
// whose token enters at position 0. Assumes CODE_W can hold NUM_SRC-1.
module intc_select
    import prio_intc_pkg::*;
#(
    parameter int        NUM_SRC = 8,
    parameter int        CODE_W  = 3,
    parameter sel_kind_e KIND    = SEL_ENCODER
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               any,
    output logic [CODE_W-1:0]  code,
    output logic [NUM_SRC-1:0] onehot
);
    generate
        if (KIND == SEL_ENCODER) begin : g_enc
            // Scan from lowest rank upward so the lowest index is written last.
            always_comb begin
                code = '0;
                for (int i = NUM_SRC - 1; i >= 0; i--) begin
                    if (cand[i]) code = CODE_W'(i);
                end
            end
            // Isolate the lowest set bit arithmetically.
            assign onehot = cand & (~cand + NUM_SRC'(1));
            assign any    = |cand;
        end else begin : g_chain
            logic [NUM_SRC:0] pass;
            assign pass[0] = 1'b1;
            for (genvar p = 0; p < NUM_SRC; p++) begin : g_pos
                // A position keeps the token if it requests, else forwards it.
                assign onehot[p]   = pass[p] & cand[p];
                assign pass[p + 1] = pass[p] & ~cand[p];
            end
            // Convert the taken position into its binary code.
            always_comb begin
                code = '0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (onehot[i]) code = code | CODE_W'(i);
                end
            end
            assign any = ~pass[NUM_SRC];
        end
    endgenerate
endmodule

// File: rtl/intc_service.sv
// In-service tracker: one bit per source. Grants set bits, end-of-service clears
// the lowest-index (highest-rank) set bit. Also gives the eligibility mask, which
// is every index strictly below the highest-rank open service.
module intc_service #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set,
    input  logic               eos,
    output logic [NUM_SRC-1:0] isr,
    output logic [NUM_SRC-1:0] allow
);
    logic [NUM_SRC-1:0] top_bit;
    logic [NUM_SRC-1:0] eos_clr;

    // Highest-rank open service as a one-hot vector (zero when idle).
    assign top_bit = isr & (~isr + NUM_SRC'(1));
    // Bits below top_bit; an idle tracker wraps to all ones.
    assign allow   = top_bit - NUM_SRC'(1);
    assign eos_clr = eos ? top_bit : '0;

    // Close the top service first, then open the newly granted one.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eos_clr) | set;
    end

    assert_isr_opened_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((isr & $past(set)) == $past(set)));
    assert_eos_idle_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && isr == '0 && set == '0) |=> (isr == '0));
    assert_eos_keeps_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && set == '0) |=> ($countones(isr) + (($past(isr) != '0) ? 1 : 0) == $countones($past(isr))));
endmodule

// File: rtl/prio_intc.sv
// Priority interrupt controller top. Index 0 ranks highest. Latches request
// edges, masks ranks at or below the open service, reports the winner and
// grants it on acknowledge. Assumes irq_req, irq_ack and irq_eos are synchronous to clk.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int        NUM_SRC = 8,
    parameter sel_kind_e SEL     = SEL_ENCODER,
    localparam int       CODE_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               irq_ack,
    input  logic               irq_eos,
    output logic               irq_out,
    output logic [CODE_W-1:0]  irq_code,
    output logic [NUM_SRC-1:0] grant
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] isr;
    logic [NUM_SRC-1:0] allow;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] win;

    intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(grant), .pend(pend)
    );

    intc_service #(.NUM_SRC(NUM_SRC)) u_svc (
        .clk(clk), .rst_n(rst_n), .set(grant), .eos(irq_eos),
        .isr(isr), .allow(allow)
    );

    // Only pending sources above the open service may compete.
    assign elig = pend & allow;

    intc_select #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W), .KIND(SEL)) u_sel (
        .cand(elig), .any(irq_out), .code(irq_code), .onehot(win)
    );

    // Return the acknowledge to the winner only while an interrupt is shown.
    assign grant = (irq_ack && irq_out) ? win : '0;

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_matches_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_out) |-> grant[irq_code]);
    assert_no_grant_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out) |-> (grant == '0));
    assert_code_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pend[irq_code]);
    assert_code_above_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((isr & ((NUM_SRC'(1) << irq_code) | ((NUM_SRC'(1) << irq_code) - NUM_SRC'(1)))) == '0));
endmodule

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
    import prio_intc_pkg::*;
    localparam int N  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          ack = 1'b0;
    logic          eos = 1'b0;
    logic          irq_a, irq_b;
    logic [CW-1:0] code_a, code_b;
    logic [N-1:0]  gnt_a, gnt_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model state.
    logic [N-1:0] m_pend = '0, m_isr = '0, m_rq = '0;

    always #10 clk = ~clk;

    prio_intc #(.NUM_SRC(N), .SEL(SEL_ENCODER)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_ack(ack), .irq_eos(eos),
        .irq_out(irq_a), .irq_code(code_a), .grant(gnt_a));

    prio_intc #(.NUM_SRC(N), .SEL(SEL_CHAIN)) dut_chain (
        .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_ack(ack), .irq_eos(eos),
        .irq_out(irq_b), .irq_code(code_b), .grant(gnt_b));

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Expected outputs from the model: lowest index pending below the top open service.
    task automatic model_out(output bit e_irq, output int e_code, output logic [N-1:0] e_gnt);
        int top;
        top = N;
        for (int i = N - 1; i >= 0; i--) if (m_isr[i]) top = i;
        e_irq = 0; e_code = 0; e_gnt = '0;
        for (int i = N - 1; i >= 0; i--)
            if (m_pend[i] && i < top) begin e_irq = 1; e_code = i; end
        if (e_irq && ack) e_gnt[e_code] = 1'b1;
    endtask

    // Drive one cycle at the falling edge, check, then advance the model at the rising edge.
    task automatic step(input logic [N-1:0] r, input bit a, input bit e, input string tag);
        bit e_irq; int e_code; logic [N-1:0] e_gnt; logic [N-1:0] low;
        req = r; ack = a; eos = e;
        #1;
        model_out(e_irq, e_code, e_gnt);
        check(irq_a == e_irq && (!e_irq || code_a == CW'(e_code)) && gnt_a == e_gnt, tag,
              $sformatf("irq=%0b code=%0d gnt=%b", irq_a, code_a, gnt_a),
              $sformatf("irq=%0b code=%0d gnt=%b", e_irq, e_code, e_gnt));
        check(irq_b == irq_a && code_b == code_a && gnt_b == gnt_a, "R9",
              $sformatf("irq=%0b code=%0d gnt=%b", irq_b, code_b, gnt_b),
              $sformatf("irq=%0b code=%0d gnt=%b", irq_a, code_a, gnt_a));
        @(posedge clk);
        low = '0;
        for (int i = N - 1; i >= 0; i--) if (m_isr[i]) low = N'(1) << i;
        m_isr  = (m_isr & ~(e ? low : '0)) | e_gnt;
        m_pend = (m_pend & ~e_gnt) | (r & ~m_rq);
        m_rq   = r;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq_a == 0 && gnt_a == '0 && irq_b == 0, "R1",
              $sformatf("irq=%0b gnt=%b", irq_a, gnt_a), "irq=0 gnt=0000");
        rst_n = 1'b1;
        step('0, 1, 0, "R1");                       // idle ack after reset
        // R2: single-cycle pulse kept pending
        step(4'b0100, 0, 0, "R2");
        step(4'b0000, 0, 0, "R2");
        step(4'b0000, 0, 0, "R2");
        // R3: simultaneous edges, lowest index wins
        step(4'b1010, 0, 0, "R3");
        step(4'b0000, 0, 0, "R3");
        // R5: grant source 1, then 2 is masked (R4)
        step(4'b0000, 1, 0, "R5");
        step(4'b0000, 0, 0, "R4");
        step(4'b0000, 1, 0, "R6");                   // ack without interrupt
        // R4: equal rank re-request is masked while 1 in service
        step(4'b0010, 0, 0, "R4");
        step(4'b0000, 0, 0, "R4");
        // R8: rank 0 preempts and nests
        step(4'b0001, 0, 0, "R8");
        step(4'b0000, 1, 0, "R8");
        step(4'b0000, 0, 0, "R8");
        step(4'b0000, 0, 1, "R8");                   // closes rank 0
        step(4'b0000, 0, 0, "R8");                   // rank 1 masks again
        step(4'b0000, 0, 1, "R7");                   // closes rank 1
        step(4'b0000, 0, 0, "R7");
        // R2: level held high across service does not re-raise
        step(4'b0000, 1, 0, "R5");
        step(4'b0000, 0, 1, "R7");
        step(4'b0000, 1, 0, "R5");
        step(4'b0000, 0, 1, "R7");
        step(4'b0000, 0, 1, "R7");                   // eos with nothing open
        step(4'b1000, 0, 0, "R2");
        step(4'b1000, 1, 1, "R7");                   // eos and ack together
        step(4'b1000, 0, 0, "R2");
        step(4'b1000, 0, 1, "R2");
        step(4'b1000, 0, 0, "R2");
        // Sweep: pseudo-random request, ack and eos patterns
        lfsr = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], lfsr[6:4] < 3'd3, lfsr[9:8] == 2'd0, "R3");
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule